// File: doc/BRIEF.md
# Parallel Code-Phase Correlator and Channel Decoder

This block recovers several parallel data channels from one spread-spectrum chip stream. The transmitter picks one of M = 2^K shifted copies of a single pseudo-noise code for each K-bit symbol. Each bit of that symbol belongs to a different channel. The receiver side gets an already demodulated binary chip stream. It feeds every accepted chip at the same time into M correlators, one per code phase. Each correlator counts agreements (XNOR) between the received chip and its own locally delayed copy of the code.

After one full code period, every correlator count is compared against a programmable threshold, and every integrator is cleared for the next symbol. The comparator flags then pass through an OR-tree decoder. Channel bit k is set when any flag whose index has bit k set is raised. The decoded bits and two detection-quality flags are registered and held until the next symbol. A one-cycle strobe marks each update.

The chip input is a qualified stream with no back-pressure. A chip is taken on every clock edge where `chip_valid` is high, and the block never stalls it. The output side is a strobe with no ready. The consumer must capture the held result before the next symbol completes, which is at least one code period of accepted chips later. `align_dly` and `thresh` are plain control inputs. They should be changed only between symbols.

Top module: `code_phase_rx`

## Requirements
- R1: The code is 31 chips long. Chip j is bit 0 of a 5-bit shift state that starts at 00001 and then advances to {s[0]^s[3], s[4:1]}. At chip position n of a symbol, correlator m compares the received chip with code chip (n - 2m - d) mod 31, where d is `align_dly`. An `align_dly` of 31 acts as 0.
- R2: Only chips with `chip_valid` high are counted and advance the chip position. While `chip_valid` is low, `rx_chip` has no effect on any result.
- R3: Each symbol's correlation counts include only that symbol's 31 chips, because every integrator restarts from zero after each symbol.
- R4: The flag of correlator m is set when its count over the symbol is strictly greater than `thresh`.
- R5: `ch_bits[k]` is the OR of the flags of every index m that has bit k set. Index 0 therefore feeds no output, and a detected symbol m reads back as `ch_bits == m`.
- R6: `no_detect` is 1 when no flag is set, and then `ch_bits` is 0. `multi_hit` is 1 when two or more flags are set. Both are updated together with `ch_bits`.
- R7: The results are registered on the edge that accepts a symbol's 31st chip. `sym_valid` is high for exactly the following cycle. `ch_bits`, `no_detect` and `multi_hit` hold their values until the next symbol completes.
- R8: Under active-low reset, all outputs are 0 and the chip position restarts at 0.
- R9: The chip stream has no back-pressure. Thirty-one consecutive valid cycles produce a result strobe with no added wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_valid | input | 1 | Qualifies `rx_chip` for this cycle |
| rx_chip | input | 1 | Demodulated, chip-aligned received chip |
| align_dly | input | 5 | Delay in chips applied to every local code phase |
| thresh | input | 5 | Detection threshold; a count must exceed it |
| sym_valid | output | 1 | One-cycle strobe: new symbol result registered |
| ch_bits | output | 4 | Recovered channel bits, one per channel |
| no_detect | output | 1 | No correlator exceeded the threshold |
| multi_hit | output | 1 | Two or more correlators exceeded the threshold |

## Verification
The bench sends all sixteen symbols, including symbol 0. A design that let index 0 reach the decoder, or that confused symbol 0 with a missed detection, would raise `no_detect` or set channel bits there.

It varies the alignment delay, including the value 31 that must act as zero, and it offsets the delay by one chip. An address-arithmetic error would then decode the wrong symbol, and an offset receiver would still claim a detection.

It places the threshold exactly at and just below the peak count and the off-peak count. A comparison using greater-or-equal, or a missing clear between back-to-back symbols, would then flip the detect and multi-hit flags.

Idle cycles with a toggling chip inside and between symbols catch a design that counts unqualified chips or lets the held outputs drift.

// File: rtl/cpr_pkg.sv
package cpr_pkg;

  localparam int unsigned CHAN_BITS_DEF = 4;
  localparam int unsigned CODE_W_DEF    = 5;
  localparam int unsigned CODE_TAP_DEF  = 3;

  typedef struct packed {
    logic none;
    logic multi;
  } det_status_t;

  // One step of the right-shifting code generator: new MSB is s[0]^s[tap].
  function automatic logic [15:0] lfsr_advance(input logic [15:0] st,
                                               input int unsigned width,
                                               input int unsigned tap);
    logic        fb;
    logic [15:0] nx;
    fb = st[0] ^ st[tap];
    nx = st >> 1;
    nx[width-1] = fb;
    return nx;
  endfunction

endpackage

// File: rtl/cpr_phase_ref.sv
module cpr_phase_ref #(
  parameter int unsigned CHAN_BITS = cpr_pkg::CHAN_BITS_DEF,
  parameter int unsigned CODE_W    = cpr_pkg::CODE_W_DEF,
  parameter int unsigned CODE_TAP  = cpr_pkg::CODE_TAP_DEF
) (
  input  logic [CODE_W-1:0]         chip_pos,
  input  logic [CODE_W-1:0]         align_dly,
  output logic [(1<<CHAN_BITS)-1:0] ref_bits
);
  localparam int unsigned CODE_LEN = (1 << CODE_W) - 1;
  localparam int unsigned NUM_PH   = 1 << CHAN_BITS;
  localparam int unsigned STEP     = (CODE_LEN + 1) / NUM_PH;
  localparam int unsigned IDX_W    = CODE_W + 2;

  function automatic logic [CODE_LEN-1:0] build_code();
    logic [15:0]         st;
    logic [CODE_LEN-1:0] c;
    st = 16'd1;
    c  = '0;
    for (int j = 0; j < CODE_LEN; j++) begin
      c[j] = st[0];
      st   = cpr_pkg::lfsr_advance(st, CODE_W, CODE_TAP);
    end
    return c;
  endfunction

  localparam logic [CODE_LEN-1:0] CODE = build_code();

  // Complement of the effective delay; the all-ones delay folds to zero.
  logic [IDX_W-1:0] dly_comp;
  always_comb begin
    if (align_dly == CODE_W'(CODE_LEN)) dly_comp = IDX_W'(CODE_LEN);
    else                                dly_comp = IDX_W'(CODE_LEN) - IDX_W'(align_dly);
  end

  generate
    for (genvar m = 0; m < NUM_PH; m++) begin : g_phase
      localparam int unsigned SHIFT_COMP = CODE_LEN - STEP * m;
      logic [IDX_W-1:0]  raw;
      logic [CODE_W-1:0] idx;
      always_comb begin
        raw = IDX_W'(chip_pos) + IDX_W'(SHIFT_COMP) + dly_comp;
        if (raw >= IDX_W'(2 * CODE_LEN))  idx = CODE_W'(raw - IDX_W'(2 * CODE_LEN));
        else if (raw >= IDX_W'(CODE_LEN)) idx = CODE_W'(raw - IDX_W'(CODE_LEN));
        else                              idx = CODE_W'(raw);
      end
      assign ref_bits[m] = CODE[idx];
    end
  endgenerate

endmodule

// File: rtl/cpr_correlator.sv
module cpr_correlator #(
  parameter int unsigned ACC_W = cpr_pkg::CODE_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             rx_chip,
  input  logic             ref_chip,
  input  logic             dump,
  input  logic [ACC_W-1:0] thresh,
  output logic             hit
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   total;
  logic             agree;

  assign agree = ~(rx_chip ^ ref_chip);
  assign total = {1'b0, acc} + {{ACC_W{1'b0}}, agree};
  assign hit   = total > {1'b0, thresh};

  always_ff @(posedge clk) begin
    if (!rst_n)       acc <= '0;
    else if (chip_en) acc <= dump ? '0 : total[ACC_W-1:0];
  end

endmodule

// File: rtl/cpr_or_decoder.sv
module cpr_or_decoder #(
  parameter int unsigned CHAN_BITS = cpr_pkg::CHAN_BITS_DEF
) (
  input  logic [(1<<CHAN_BITS)-1:0] flags,
  output logic [CHAN_BITS-1:0]      bits,
  output cpr_pkg::det_status_t      status
);
  localparam int unsigned NUM_PH = 1 << CHAN_BITS;
  localparam int unsigned CNT_W  = $clog2(NUM_PH + 1);

  generate
    for (genvar k = 0; k < CHAN_BITS; k++) begin : g_chan
      logic or_acc;
      always_comb begin
        or_acc = 1'b0;
        for (int m = 0; m < NUM_PH; m++) begin
          if (((m >> k) & 1) == 1) or_acc = or_acc | flags[m];
        end
      end
      assign bits[k] = or_acc;
    end
  endgenerate

  logic [CNT_W-1:0] n_set;
  always_comb begin
    n_set = '0;
    for (int m = 0; m < NUM_PH; m++) n_set = n_set + CNT_W'(flags[m]);
  end

  assign status.none  = (n_set == '0);
  assign status.multi = (n_set > CNT_W'(1));

endmodule

// File: rtl/code_phase_rx.sv
module code_phase_rx #(
  parameter int unsigned CHAN_BITS = cpr_pkg::CHAN_BITS_DEF,
  parameter int unsigned CODE_W    = cpr_pkg::CODE_W_DEF,
  parameter int unsigned CODE_TAP  = cpr_pkg::CODE_TAP_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chip_valid,
  input  logic                 rx_chip,
  input  logic [CODE_W-1:0]    align_dly,
  input  logic [CODE_W-1:0]    thresh,
  output logic                 sym_valid,
  output logic [CHAN_BITS-1:0] ch_bits,
  output logic                 no_detect,
  output logic                 multi_hit
);
  localparam int unsigned CODE_LEN = (1 << CODE_W) - 1;
  localparam int unsigned NUM_PH   = 1 << CHAN_BITS;

  logic [CODE_W-1:0]    chip_pos;
  logic                 last_chip;
  logic                 dump;
  logic [NUM_PH-1:0]    ref_bits;
  logic [NUM_PH-1:0]    hit_flags;
  logic [CHAN_BITS-1:0] dec_bits;
  cpr_pkg::det_status_t dec_status;

  assign last_chip = (chip_pos == CODE_W'(CODE_LEN - 1));
  assign dump      = chip_valid & last_chip;

  always_ff @(posedge clk) begin
    if (!rst_n)          chip_pos <= '0;
    else if (chip_valid) chip_pos <= last_chip ? '0 : chip_pos + CODE_W'(1);
  end

  cpr_phase_ref #(
    .CHAN_BITS(CHAN_BITS), .CODE_W(CODE_W), .CODE_TAP(CODE_TAP)
  ) u_phase_ref (
    .chip_pos (chip_pos),
    .align_dly(align_dly),
    .ref_bits (ref_bits)
  );

  generate
    for (genvar m = 0; m < NUM_PH; m++) begin : g_corr
      cpr_correlator #(.ACC_W(CODE_W)) u_corr (
        .clk     (clk),
        .rst_n   (rst_n),
        .chip_en (chip_valid),
        .rx_chip (rx_chip),
        .ref_chip(ref_bits[m]),
        .dump    (dump),
        .thresh  (thresh),
        .hit     (hit_flags[m])
      );
    end
  endgenerate

  cpr_or_decoder #(.CHAN_BITS(CHAN_BITS)) u_decoder (
    .flags (hit_flags),
    .bits  (dec_bits),
    .status(dec_status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_valid <= 1'b0;
      ch_bits   <= '0;
      no_detect <= 1'b0;
      multi_hit <= 1'b0;
    end else begin
      sym_valid <= dump;
      if (dump) begin
        ch_bits   <= dec_bits;
        no_detect <= dec_status.none;
        multi_hit <= dec_status.multi;
      end
    end
  end

endmodule

// File: rtl/code_phase_rx_chk.sv
module code_phase_rx_chk #(
  parameter int unsigned CHAN_BITS = cpr_pkg::CHAN_BITS_DEF
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 chip_valid,
  input logic                 sym_valid,
  input logic [CHAN_BITS-1:0] ch_bits,
  input logic                 no_detect,
  input logic                 multi_hit
);

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> !sym_valid)
    else $error("strobe longer than one cycle");

  assert_strobe_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> $past(chip_valid))
    else $error("strobe without an accepted chip before it");

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |-> ($stable(ch_bits) && $stable(no_detect) && $stable(multi_hit)))
    else $error("result changed without strobe");

  assert_status_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(no_detect && multi_hit))
    else $error("no_detect and multi_hit together");

  assert_nodetect_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    no_detect |-> (ch_bits == '0))
    else $error("channel bits set without detection");

  assert_multi_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hit |-> (ch_bits != '0))
    else $error("several hits decoded to zero");

endmodule

bind code_phase_rx code_phase_rx_chk #(.CHAN_BITS(CHAN_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chip_valid(chip_valid),
  .sym_valid (sym_valid),
  .ch_bits   (ch_bits),
  .no_detect (no_detect),
  .multi_hit (multi_hit)
);

// File: tb/test_code_phase_rx.sv
`timescale 1ns/1ps
module test_code_phase_rx;
  localparam int K    = 4;
  localparam int W    = 5;
  localparam int L    = 31;
  localparam int M    = 16;
  localparam int STEP = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         chip_valid = 1'b0;
  logic         rx_chip = 1'b0;
  logic [W-1:0] align_dly = '0;
  logic [W-1:0] thresh = 5'd23;
  logic         sym_valid;
  logic [K-1:0] ch_bits;
  logic         no_detect;
  logic         multi_hit;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  bit pn [L];
  bit tx [L];
  int prev_bits = 0;

  always #2.5 clk = ~clk;

  code_phase_rx i_code_phase_rx (
    .clk(clk), .rst_n(rst_n), .chip_valid(chip_valid), .rx_chip(rx_chip),
    .align_dly(align_dly), .thresh(thresh), .sym_valid(sym_valid),
    .ch_bits(ch_bits), .no_detect(no_detect), .multi_hit(multi_hit)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic build_pn();
    logic [4:0] s;
    s = 5'b00001;
    for (int j = 0; j < L; j++) begin
      pn[j] = s[0];
      s = {s[0] ^ s[3], s[4:1]};
    end
  endtask

  task automatic load_symbol(int sym, int lag);
    for (int n = 0; n < L; n++) tx[n] = pn[(n - STEP * sym - lag + 3 * L) % L];
  endtask

  // Sends the chips in tx, then checks the registered result against a model.
  task automatic run_symbol(int thr, int dly, int gaps, string req);
    int d_eff, exp_bits, hits, cnt;
    align_dly = W'(dly);
    thresh    = W'(thr);
    d_eff     = (dly == L) ? 0 : dly;
    exp_bits  = 0;
    hits      = 0;
    for (int m = 0; m < M; m++) begin
      cnt = 0;
      for (int n = 0; n < L; n++)
        if (tx[n] == pn[(n - STEP * m - d_eff + 3 * L) % L]) cnt++;
      if (cnt > thr) begin
        hits++;
        exp_bits = exp_bits | m;
      end
    end
    for (int n = 0; n < L; n++) begin
      @(negedge clk);
      chip_valid = 1'b1;
      rx_chip    = tx[n];
      if (n == L / 2) begin
        check_eq("R7", "bits held mid-symbol", int'(ch_bits), prev_bits);
        check_eq("R7", "no strobe mid-symbol", int'(sym_valid), 0);
      end
      if (gaps > 0 && (n % 6) == 5 && n != L - 1) begin
        repeat (gaps) begin
          @(negedge clk);
          chip_valid = 1'b0;
          rx_chip    = ~tx[n];
        end
      end
    end
    @(negedge clk);
    chip_valid = 1'b0;
    check_eq("R7", "strobe after last chip", int'(sym_valid), 1);
    check_eq(req, "channel bits", int'(ch_bits), exp_bits);
    check_eq("R6", "no_detect", int'(no_detect), (hits == 0) ? 1 : 0);
    check_eq("R6", "multi_hit", int'(multi_hit), (hits > 1) ? 1 : 0);
    @(negedge clk);
    check_eq("R7", "strobe one cycle only", int'(sym_valid), 0);
    check_eq("R7", "bits held after strobe", int'(ch_bits), exp_bits);
    prev_bits = exp_bits;
  endtask

  task automatic t_reset();
    check_eq("R8", "sym_valid in reset", int'(sym_valid), 0);
    check_eq("R8", "ch_bits in reset", int'(ch_bits), 0);
    check_eq("R8", "no_detect in reset", int'(no_detect), 0);
    check_eq("R8", "multi_hit in reset", int'(multi_hit), 0);
  endtask

  task automatic t_all_symbols();
    for (int s = 0; s < M; s++) begin
      load_symbol(s, 0);
      run_symbol(23, 0, 0, "R5 R9");
    end
  endtask

  task automatic t_alignment();
    load_symbol(11, 7);  run_symbol(23, 7, 0, "R1");
    load_symbol(6, 30);  run_symbol(23, 30, 0, "R1");
    load_symbol(13, 0);  run_symbol(23, 31, 0, "R1 fold");
    load_symbol(5, 4);   run_symbol(23, 5, 0, "R1 offset");
  endtask

  task automatic t_threshold();
    load_symbol(9, 0);
    run_symbol(30, 0, 0, "R4 peak above");
    run_symbol(31, 0, 0, "R4 peak equal");
    run_symbol(14, 0, 0, "R4 all above");
    run_symbol(15, 0, 0, "R4 side equal");
  endtask

  task automatic t_back_to_back();
    load_symbol(15, 0); run_symbol(23, 0, 0, "R3");
    load_symbol(1, 0);  run_symbol(23, 0, 0, "R3");
    load_symbol(1, 0);  run_symbol(23, 0, 0, "R3 repeat");
  endtask

  task automatic t_gaps();
    load_symbol(12, 3);
    run_symbol(23, 3, 3, "R2 gaps");
  endtask

  task automatic t_noise();
    load_symbol(10, 2);
    for (int f = 0; f < 7; f++) tx[f * 4] = ~tx[f * 4];
    run_symbol(23, 2, 0, "R4 noisy");
  endtask

  task automatic t_idle_hold();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chip_valid = 1'b0;
      rx_chip    = i[0];
    end
    check_eq("R2", "idle keeps strobe low", int'(sym_valid), 0);
    check_eq("R2", "idle keeps bits", int'(ch_bits), prev_bits);
    load_symbol(7, 0);
    run_symbol(23, 0, 0, "R2 after idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R7 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    build_pn();
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_symbols();
    t_alignment();
    t_threshold();
    t_back_to_back();
    t_gaps();
    t_noise();
    t_idle_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule